// File: doc/BRIEF.md
# Unstable high-byte store sequencer

This block runs the bus cycles of a small family of undocumented 8-bit CPU store instructions. Each of them writes a register value ANDed with a byte H. H is the high byte of the base address plus one, modulo 256. The surrounding core has already decoded the opcode and fetched the base operand. It presents a one-cycle `start` together with an operation code, the A, X, Y and S register values and the 16-bit base address. For the indirect form, the base address is the pointer-derived address.

The sequencer then steps through three phases. It adds the selected index register to the low address byte. It issues a dummy read at the uncorrected address, where RDY can stall it. It then writes the masked byte. If the index addition carried out of the low byte, the high byte of the write address is damaged: it becomes (base high + 1) ANDed with the stored value. The stack form also replaces S with A & X before its write. A one-cycle `done` tells the core that the instruction has finished. No register other than S changes, and no flag changes.

Top module: `hb_store_seq`

## Requirements
- R1: A `start` accepted in idle runs exactly one index-add cycle, then the dummy-read step, then one write cycle. Without a stall, `mem_rd` is high 2 cycles after the start edge and `mem_wr` is high 3 cycles after it. `busy` is high from the cycle after the start edge until the write cycle ends.
- R2: During the dummy read, `mem_addr` = {base[15:8], (base[7:0] + index) mod 256}, with no carry correction.
- R3: While `rdy` is low in the dummy-read step, `mem_rd` is low, `mem_addr` holds, and the step repeats. The write follows in the cycle after the first read cycle with `rdy` high.
- R4: Operation code 0 writes Y & H. Code 1 writes X & H. Codes 2, 3 and 4 write A & X & H. H = (base[15:8] + 1) mod 256.
- R5: Code 0 is indexed by X. Codes 1, 2, 3 and 4 are indexed by Y.
- R6: The write address low byte equals the dummy-read low byte. With no carry from the index addition, the write address high byte is base[15:8]. With a carry, it is H ANDed with the stored value, which is Y for code 0, X for code 1, and A & X otherwise.
- R7: For code 3, `s_out` changes to A & X in the write cycle. For every other code, `s_out` keeps the S value given at start.
- R8: `done` is high for exactly the one cycle after the write cycle, and `mem_wr` is low in that cycle.
- R9: A synchronous active-high `rst` leaves the unit idle, with `mem_rd`, `mem_wr`, `done` and `busy` low.
- R10: A `start` with operation code 5, 6 or 7 is ignored: the unit stays idle and drives no bus strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled in idle) |
| op | input | 3 | Operation code, 0 to 4 valid |
| reg_a | input | 8 | Accumulator value |
| reg_x | input | 8 | X index value |
| reg_y | input | 8 | Y index value |
| reg_s | input | 8 | Stack pointer value |
| base | input | 16 | Base address (absolute operand or pointer-derived address) |
| rdy | input | 1 | Ready; low stalls the dummy-read step |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| s_out | output | 8 | Stack pointer after the instruction |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Instruction in progress |

## Verification
The hardest case to reach is the page-crossing write when RDY is also low. Here the write address must carry the damaged high byte, and the stall must not move the dummy-read address. The sweep steps every operation code through base and register values picked so that about half the index additions carry. Some cases use a base high byte of FF, which makes H zero. It also varies the number of stall cycles from zero to two on every vector. This checks the masked high byte, the unchanged low byte and the held read address in every pairing of code, carry and stall.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [2:0] {
    OP_STORE_Y   = 3'd0,
    OP_STORE_X   = 3'd1,
    OP_STORE_AX  = 3'd2,
    OP_STORE_STK = 3'd3,
    OP_STORE_IND = 3'd4
  } hbs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADD  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } hbs_state_e;
endpackage

// File: rtl/hbs_operand_sel.sv
module hbs_operand_sel #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_x,
  input  logic [DATA_W-1:0] reg_y,
  output logic [DATA_W-1:0] index,
  output logic [DATA_W-1:0] value,
  output logic              loads_s,
  output logic              valid
);
  import hbs_pkg::*;

  always_comb begin
    index   = reg_y;
    value   = reg_a & reg_x;
    loads_s = 1'b0;
    valid   = 1'b1;
    case (op)
      OP_STORE_Y:   begin index = reg_x; value = reg_y; end
      OP_STORE_X:   value = reg_x;
      OP_STORE_AX:  ;
      OP_STORE_STK: loads_s = 1'b1;
      OP_STORE_IND: ;
      default:      valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/hbs_index_add.sv
module hbs_index_add #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] index,
  output logic [DATA_W-1:0] sum,
  output logic              carry
);
  logic [DATA_W:0] wide;
  assign wide  = {1'b0, lo} + {1'b0, index};
  assign sum   = wide[DATA_W-1:0];
  assign carry = wide[DATA_W];
endmodule

// File: rtl/hbs_hi_fix.sv
module hbs_hi_fix #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] base_hi,
  input  logic              carry,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] h_next,
  output logic [DATA_W-1:0] wr_hi
);
  assign h_next = base_hi + DATA_W'(1);
  assign wr_hi  = carry ? (h_next & value) : base_hi;
endmodule

// File: rtl/hb_store_seq.sv
module hb_store_seq #(
  parameter int DATA_W = 8,
  parameter int OP_W   = 3,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_x,
  input  logic [DATA_W-1:0] reg_y,
  input  logic [DATA_W-1:0] reg_s,
  input  logic [ADDR_W-1:0] base,
  input  logic              rdy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] s_out,
  output logic              done,
  output logic              busy
);
  import hbs_pkg::*;

  hbs_state_e        state_q;
  logic [DATA_W-1:0] idx_q, val_q, sum_q, h_q, s_q, wdata_q;
  logic [ADDR_W-1:0] base_q, addr_q;
  logic              ld_s_q, carry_q, wr_q, done_q;

  logic [DATA_W-1:0] sel_idx, sel_val, add_sum, h_calc, wr_hi;
  logic              sel_lds, sel_ok, add_carry;

  hbs_operand_sel #(.DATA_W(DATA_W)) u_sel (
    .op(op[2:0]), .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
    .index(sel_idx), .value(sel_val), .loads_s(sel_lds), .valid(sel_ok)
  );

  hbs_index_add #(.DATA_W(DATA_W)) u_add (
    .lo(base_q[DATA_W-1:0]), .index(idx_q), .sum(add_sum), .carry(add_carry)
  );

  hbs_hi_fix #(.DATA_W(DATA_W)) u_fix (
    .base_hi(base_q[ADDR_W-1:DATA_W]), .carry(carry_q), .value(val_q),
    .h_next(h_calc), .wr_hi(wr_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      val_q   <= '0;
      sum_q   <= '0;
      h_q     <= '0;
      s_q     <= '0;
      wdata_q <= '0;
      base_q  <= '0;
      addr_q  <= '0;
      ld_s_q  <= 1'b0;
      carry_q <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start && sel_ok) begin
            idx_q   <= sel_idx;
            val_q   <= sel_val;
            ld_s_q  <= sel_lds;
            base_q  <= base;
            s_q     <= reg_s;
            state_q <= ST_ADD;
          end
        end
        ST_ADD: begin
          sum_q   <= add_sum;
          carry_q <= add_carry;
          addr_q  <= {base_q[ADDR_W-1:DATA_W], add_sum};
          state_q <= ST_RD;
        end
        ST_RD: begin
          h_q <= h_calc;
          if (rdy) begin
            addr_q  <= {wr_hi, sum_q};
            wdata_q <= val_q & h_calc;
            wr_q    <= 1'b1;
            if (ld_s_q) s_q <= val_q;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          wr_q    <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_rd    = (state_q == ST_RD) && rdy;
  assign mem_wr    = wr_q;
  assign mem_wdata = wdata_q;
  assign s_out     = s_q;
  assign done      = done_q;
  assign busy      = (state_q != ST_IDLE);

  p_rd_needs_rdy_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> rdy);
  p_addr_hold_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD && !rdy) |=> $stable(mem_addr));
  p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (done && !mem_wr));
  p_wdata_masked_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ((mem_wdata & ~h_q) == '0));
  p_hi_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && carry_q) |-> ((mem_addr[ADDR_W-1:DATA_W] & ~h_q) == '0));
  p_low_kept_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> (mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0])));
  p_s_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !ld_s_q) |=> $stable(s_out));
endmodule

// File: tb/hb_store_seq_test.sv
module hb_store_seq_test;
  logic        clk = 1'b0;
  logic        rst, start, rdy;
  logic [2:0]  op;
  logic [7:0]  reg_a, reg_x, reg_y, reg_s;
  logic [15:0] base;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, done, busy;
  logic [7:0]  mem_wdata, s_out;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hb_store_seq uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .reg_a(reg_a), .reg_x(reg_x),
    .reg_y(reg_y), .reg_s(reg_s), .base(base), .rdy(rdy), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .s_out(s_out),
    .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [7:0] a, input logic [7:0] x,
                     input logic [7:0] y, input logic [7:0] s, input logic [15:0] b,
                     input int stall);
    logic [7:0] idx, val, h, lo, whi, exp_s;
    logic [8:0] wide;
    idx   = (o == 3'd0) ? x : y;
    val   = (o == 3'd0) ? y : (o == 3'd1) ? x : (a & x);
    h     = b[15:8] + 8'd1;
    wide  = {1'b0, b[7:0]} + {1'b0, idx};
    lo    = wide[7:0];
    whi   = wide[8] ? (h & val) : b[15:8];
    exp_s = (o == 3'd3) ? (a & x) : s;
    @(negedge clk);
    op = o; reg_a = a; reg_x = x; reg_y = y; reg_s = s; base = b;
    start = 1'b1; rdy = (stall == 0);
    @(negedge clk);
    start = 1'b0;
    reg_a = ~a; reg_x = ~x; reg_y = ~y; reg_s = ~s; base = ~b;
    chk(busy && !mem_rd && !mem_wr, "R1 add cycle", {busy, mem_rd, mem_wr}, 3'b100);
    @(negedge clk);
    for (int k = 0; k < stall; k++) begin
      chk(!mem_rd && !mem_wr, "R3 stalled read", {mem_rd, mem_wr}, 2'b00);
      chk(mem_addr == {b[15:8], lo}, "R3 address held", mem_addr, {b[15:8], lo});
      if (k == stall - 1) rdy = 1'b1;
      else @(negedge clk);
    end
    #1;
    chk(mem_rd && !mem_wr, "R1 dummy read", {mem_rd, mem_wr}, 2'b10);
    chk(mem_addr == {b[15:8], lo}, "R2 R5 read address", mem_addr, {b[15:8], lo});
    @(negedge clk);
    chk(mem_wr && !mem_rd && busy, "R1 write cycle", {mem_wr, mem_rd, busy}, 3'b101);
    chk(mem_wdata == (val & h), "R4 write data", mem_wdata, val & h);
    chk(mem_addr == {whi, lo}, "R6 write address", mem_addr, {whi, lo});
    chk(s_out == exp_s, "R7 stack during write", s_out, exp_s);
    @(negedge clk);
    chk(done && !mem_wr && !busy, "R8 done pulse", {done, mem_wr, busy}, 3'b100);
    chk(s_out == exp_s, "R7 stack after", s_out, exp_s);
    @(negedge clk);
    chk(!done, "R8 done single cycle", done, 0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; rdy = 1'b1; op = '0;
    reg_a = '0; reg_x = '0; reg_y = '0; reg_s = '0; base = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!mem_rd && !mem_wr && !done && !busy, "R9 reset state",
        {mem_rd, mem_wr, done, busy}, 0);

    for (int o = 0; o < 5; o++) begin
      for (int i = 0; i < 24; i++) begin
        run(3'(o), 8'(i * 37 + o * 11 + 5), 8'(i * 91 + 3), 8'(i * 53 + o * 29 + 1),
            8'(i * 17 + 7), 16'(i * 16'h2F1D + o * 16'h0731 + 16'h00C0), i % 3);
      end
      run(3'(o), 8'hFF, 8'h01, 8'h01, 8'h40, 16'hFFFF, 1);
      run(3'(o), 8'hFF, 8'h00, 8'h00, 8'h40, 16'h12FF, 0);
      run(3'(o), 8'hF3, 8'hFF, 8'hFF, 8'h22, 16'h0100, 2);
      run(3'(o), 8'h5A, 8'hFF, 8'hFF, 8'h22, 16'h7F80, 0);
    end

    for (int o = 5; o < 8; o++) begin
      @(negedge clk);
      op = 3'(o); start = 1'b1; rdy = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 3; k++) begin
        chk(!busy && !mem_rd && !mem_wr, "R10 invalid code ignored",
            {busy, mem_rd, mem_wr}, 0);
        @(negedge clk);
      end
    end

    run(3'd3, 8'hC3, 8'h3C, 8'h10, 8'h99, 16'h20F8, 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !mem_wr, "R9 reset after run", {busy, done, mem_wr}, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule